// File: doc/BRIEF.md
# Cascaded Sticky Interrupt Concentrator

The block gathers a set of level-signalled serial-style interrupt sources into a single interrupt line through two cascaded latching stages, all controlled from one 32-bit register interface. The first stage, the host stage, captures any source that is seen high into a sticky status word. It combines that word with a mask and a global enable to form one aggregate request.

The aggregate request appears as a live bit in the read-only input register of the second stage, the concentrator stage. That stage folds its masked input into a second sticky status word and raises the interrupt output while any status bit is set. Software services an interrupt by clearing status bits with write-one-to-clear writes. The latches re-evaluate every cycle, so any register write or newly captured source takes effect without a separate trigger. A polarity register and two routing registers are provided as plain storage.

Register offsets (byte addresses, 4-byte accesses only): routing A 0x08, routing B 0x0C, host control 0x30, host mask 0x34, host status 0x38, concentrator status 0x50, concentrator mask 0x54, polarity 0x58, concentrator input 0x5C.

Top module: `irqc_top`

## Requirements
- R1: After reset every register reads zero and `irq_out` is low.
- R2: A high level on source n sets bit (31 - n) of the host status register (0x38). Source 0 maps to bit 31 and source 16 to bit 15. The bit stays set after the source returns low, and a low source sets nothing.
- R3: Bit 11 (0x800) of the concentrator input register (0x5C) reads 1 exactly when bit 31 of host control (0x30) is set and host status AND host mask (0x34) is non-zero. All other bits of 0x5C read 0.
- R4: Each cycle the concentrator status (0x50) gains the bits of input AND concentrator mask (0x54). Those bits stay set after the input drops.
- R5: `irq_out` is high exactly when the concentrator status is non-zero.
- R6: A write to 0x38 or 0x50 clears the status bits written as 1 and leaves the others unchanged.
- R7: Clearing a concentrator status bit whose masked input is still high leaves that bit set, because it latches again in the same cycle.
- R8: The polarity (0x58) and routing (0x08, 0x0C) registers read back what was written and have no effect on interrupt behaviour.
- R9: A read of an unimplemented offset returns 0xFFFFFFFF, and a write to one changes no register.
- R10: An access whose size is not 4 bytes returns 0xFFFFFFFF on a read and is ignored on a write.
- R11: Writes to the concentrator input register (0x5C) have no effect on it.
- R12: A read request produces exactly one response, with `rsp_valid` high, in the cycle after the request is accepted. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_size | input | 3 | Access size in bytes; only 4 is valid |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| src_lvl | input | 17 | Level of each serial-style interrupt source |
| irq_out | output | 1 | Aggregated interrupt line |

## Verification
The hardest state to reach is a concentrator status bit that software tries to clear while its masked input is still being asserted by the host stage. The clear must lose to the re-latch in that cycle, and a later clear must win once the host bit is gone. The stimulus builds that state in order. It pulses sources, unmasks one source and sets the host enable so that bit 11 of the input register is live, and then unmasks it in the concentrator. It then clears the concentrator status while the input is still live. Only after that does it remove the host bit with its own write-one-to-clear and clear the concentrator a second time.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int DW     = 32;
    localparam int OFFS_W = 8;

    localparam logic [OFFS_W-1:0] OFF_ROUTE_A = 8'h08;
    localparam logic [OFFS_W-1:0] OFF_ROUTE_B = 8'h0C;
    localparam logic [OFFS_W-1:0] OFF_H_CTRL  = 8'h30;
    localparam logic [OFFS_W-1:0] OFF_H_MASK  = 8'h34;
    localparam logic [OFFS_W-1:0] OFF_H_STAT  = 8'h38;
    localparam logic [OFFS_W-1:0] OFF_C_STAT  = 8'h50;
    localparam logic [OFFS_W-1:0] OFF_C_MASK  = 8'h54;
    localparam logic [OFFS_W-1:0] OFF_C_POL   = 8'h58;
    localparam logic [OFFS_W-1:0] OFF_C_IN    = 8'h5C;

    localparam int ENABLE_BIT = 31;
    localparam int AGG_BIT    = 11;
    localparam logic [2:0] WORD_BYTES = 3'd4;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_ROUTE_A,
        SEL_ROUTE_B,
        SEL_H_CTRL,
        SEL_H_MASK,
        SEL_H_STAT,
        SEL_C_STAT,
        SEL_C_MASK,
        SEL_C_POL,
        SEL_C_IN
    } reg_sel_e;

    typedef struct packed {
        logic          en;
        reg_sel_e      sel;
        logic [DW-1:0] data;
    } wr_cmd_t;

    function automatic reg_sel_e decode_offs(input logic [OFFS_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFF_ROUTE_A: s = SEL_ROUTE_A;
            OFF_ROUTE_B: s = SEL_ROUTE_B;
            OFF_H_CTRL:  s = SEL_H_CTRL;
            OFF_H_MASK:  s = SEL_H_MASK;
            OFF_H_STAT:  s = SEL_H_STAT;
            OFF_C_STAT:  s = SEL_C_STAT;
            OFF_C_MASK:  s = SEL_C_MASK;
            OFF_C_POL:   s = SEL_C_POL;
            OFF_C_IN:    s = SEL_C_IN;
            default:     s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/irqc_regif.sv
module irqc_regif
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [OFFS_W-1:0] req_addr,
    input  logic [2:0]        req_size,
    input  logic [DW-1:0]     req_wdata,
    input  logic [DW-1:0]     rd_value,
    output reg_sel_e          rd_sel,
    output wr_cmd_t           wr,
    output logic              rsp_valid,
    output logic [DW-1:0]     rsp_rdata
);

    reg_sel_e sel;
    logic     size_ok;
    logic     hit;

    always_comb begin
        sel     = decode_offs(req_addr);
        size_ok = (req_size == WORD_BYTES);
        hit     = size_ok && (sel != SEL_NONE);
        rd_sel  = hit ? sel : SEL_NONE;
        wr.en   = req_valid && req_write && hit;
        wr.sel  = sel;
        wr.data = req_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            if (req_valid && !req_write)
                rsp_rdata <= hit ? rd_value : '1;
        end
    end

    // R12
    rsp_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid);

    // R12
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |=> !rsp_valid);

    // R9
    miss_reads_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && !hit) |=> (rsp_rdata == '1));

endmodule

// File: rtl/irqc_host_stage.sv
module irqc_host_stage
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 17
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_lvl,
    input  wr_cmd_t            wr,
    output logic [DW-1:0]      ctrl,
    output logic [DW-1:0]      mask,
    output logic [DW-1:0]      stat,
    output logic               agg_out
);

    localparam int LOW_BITS = DW - NUM_SRC;

    logic [DW-1:0] set_vec;
    logic [DW-1:0] clr_vec;

    // Source n lands on bit DW-1-n.
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_map
        assign set_vec[DW-1-n] = src_lvl[n];
    end
    if (LOW_BITS > 0) begin : g_fill
        assign set_vec[LOW_BITS-1:0] = '0;
    end

    assign clr_vec = (wr.en && wr.sel == SEL_H_STAT) ? wr.data : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            mask <= '0;
            stat <= '0;
        end else begin
            if (wr.en && wr.sel == SEL_H_CTRL) ctrl <= wr.data;
            if (wr.en && wr.sel == SEL_H_MASK) mask <= wr.data;
            stat <= (stat & ~clr_vec) | set_vec;
        end
    end

    assign agg_out = ctrl[ENABLE_BIT] && (|(stat & mask));

    // R2
    host_stat_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr.en && wr.sel == SEL_H_STAT) |=> ((stat & $past(stat)) == $past(stat)));

    // R2
    host_src_capture_chk: assert property (@(posedge clk) disable iff (rst)
        src_lvl[0] |=> stat[DW-1]);

endmodule

// File: rtl/irqc_conc_stage.sv
module irqc_conc_stage
    import irqc_pkg::*;
#(
    parameter int NUM_ROUTE = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] live_in,
    input  wr_cmd_t       wr,
    output logic [DW-1:0] stat,
    output logic [DW-1:0] mask,
    output logic [DW-1:0] pol,
    output logic [DW-1:0] route [NUM_ROUTE]
);

    logic [DW-1:0] clr_vec;
    logic [DW-1:0] hit_vec;

    assign clr_vec = (wr.en && wr.sel == SEL_C_STAT) ? wr.data : '0;
    assign hit_vec = live_in & mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
            mask <= '0;
            pol  <= '0;
        end else begin
            if (wr.en && wr.sel == SEL_C_MASK) mask <= wr.data;
            if (wr.en && wr.sel == SEL_C_POL)  pol  <= wr.data;
            stat <= (stat & ~clr_vec) | hit_vec;
        end
    end

    for (genvar r = 0; r < NUM_ROUTE; r++) begin : g_route
        localparam reg_sel_e MY_SEL = (r == 0) ? SEL_ROUTE_A : SEL_ROUTE_B;
        always_ff @(posedge clk) begin
            if (rst)
                route[r] <= '0;
            else if (wr.en && wr.sel == MY_SEL)
                route[r] <= wr.data;
        end
    end

    // R4
    conc_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (|(live_in & mask)) |=> (|stat));

    // R4
    conc_no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
        !(|(live_in & mask)) |=> ((stat & ~$past(stat)) == '0));

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 17
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [OFFS_W-1:0]  req_addr,
    input  logic [2:0]         req_size,
    input  logic [DW-1:0]      req_wdata,
    output logic               rsp_valid,
    output logic [DW-1:0]      rsp_rdata,
    input  logic [NUM_SRC-1:0] src_lvl,
    output logic               irq_out
);

    localparam int NUM_ROUTE = 2;

    wr_cmd_t       wr;
    reg_sel_e      rd_sel;
    logic [DW-1:0] rd_value;

    logic [DW-1:0] h_ctrl, h_mask, h_stat;
    logic          h_agg;
    logic [DW-1:0] c_in, c_stat, c_mask, c_pol;
    logic [DW-1:0] c_route [NUM_ROUTE];

    irqc_regif u_regif (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .rd_value  (rd_value),
        .rd_sel    (rd_sel),
        .wr        (wr),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    irqc_host_stage #(.NUM_SRC(NUM_SRC)) u_host (
        .clk     (clk),
        .rst     (rst),
        .src_lvl (src_lvl),
        .wr      (wr),
        .ctrl    (h_ctrl),
        .mask    (h_mask),
        .stat    (h_stat),
        .agg_out (h_agg)
    );

    always_comb begin
        c_in          = '0;
        c_in[AGG_BIT] = h_agg;
    end

    irqc_conc_stage #(.NUM_ROUTE(NUM_ROUTE)) u_conc (
        .clk     (clk),
        .rst     (rst),
        .live_in (c_in),
        .wr      (wr),
        .stat    (c_stat),
        .mask    (c_mask),
        .pol     (c_pol),
        .route   (c_route)
    );

    always_comb begin
        case (rd_sel)
            SEL_ROUTE_A: rd_value = c_route[0];
            SEL_ROUTE_B: rd_value = c_route[1];
            SEL_H_CTRL:  rd_value = h_ctrl;
            SEL_H_MASK:  rd_value = h_mask;
            SEL_H_STAT:  rd_value = h_stat;
            SEL_C_STAT:  rd_value = c_stat;
            SEL_C_MASK:  rd_value = c_mask;
            SEL_C_POL:   rd_value = c_pol;
            SEL_C_IN:    rd_value = c_in;
            default:     rd_value = '1;
        endcase
    end

    assign irq_out = |c_stat;

    // R5
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_out) |-> $past(|(c_in & c_mask)));

    // R3
    agg_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(c_in[AGG_BIT]) |-> h_ctrl[ENABLE_BIT]);

endmodule

// File: tb/irqc_top_test.sv
module irqc_top_test;
    import irqc_pkg::*;

    localparam int NSRC = 17;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [OFFS_W-1:0] req_addr = '0;
    logic [2:0]        req_size = 3'd4;
    logic [DW-1:0]     req_wdata = '0;
    logic              rsp_valid;
    logic [DW-1:0]     rsp_rdata;
    logic [NSRC-1:0]   src_lvl = '0;
    logic              irq_out;

    int n_checks = 0;
    int n_errors = 0;

    logic [DW-1:0] exp_q [$];
    string         tag_q [$];

    always #10 clk = ~clk;

    irqc_top #(.NUM_SRC(NSRC)) uut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .src_lvl   (src_lvl),
        .irq_out   (irq_out)
    );

    task automatic report;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    // Monitor: pops expected read data as responses arrive.
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                n_checks++;
                n_errors++;
                $display("FAIL R12 unexpected response: actual %h expected none", rsp_rdata);
            end else begin
                logic [DW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_checks++;
                if (rsp_rdata !== e) begin
                    n_errors++;
                    $display("FAIL %s: actual %h expected %h", t, rsp_rdata, e);
                end
            end
        end
    end

    task automatic access(input logic w, input logic [OFFS_W-1:0] a,
                          input logic [2:0] sz, input logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = w;
        req_addr  = a;
        req_size  = sz;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic wr32(input logic [OFFS_W-1:0] a, input logic [DW-1:0] d);
        access(1'b1, a, 3'd4, d);
    endtask

    task automatic rd(input logic [OFFS_W-1:0] a, input logic [2:0] sz,
                      input logic [DW-1:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        access(1'b0, a, sz, '0);
    endtask

    task automatic rd32(input logic [OFFS_W-1:0] a, input logic [DW-1:0] e, input string t);
        rd(a, 3'd4, e, t);
    endtask

    task automatic chk_irq(input logic e, input string t);
        @(negedge clk);
        n_checks++;
        if (irq_out !== e) begin
            n_errors++;
            $display("FAIL %s irq_out: actual %b expected %b", t, irq_out, e);
        end
    endtask

    task automatic pulse_src(input int n);
        @(negedge clk);
        src_lvl[n] = 1'b1;
        @(negedge clk);
        src_lvl[n] = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk_irq(1'b0, "R1");
        rd32(8'h30, 32'h0, "R1 host ctrl");
        rd32(8'h34, 32'h0, "R1 host mask");
        rd32(8'h38, 32'h0, "R1 host stat");
        rd32(8'h50, 32'h0, "R1 conc stat");
        rd32(8'h54, 32'h0, "R1 conc mask");
        rd32(8'h58, 32'h0, "R1 polarity");
        rd32(8'h5C, 32'h0, "R1 conc input");
        rd32(8'h08, 32'h0, "R1 route A");
        rd32(8'h0C, 32'h0, "R1 route B");

        // R2 capture and stickiness
        pulse_src(0);
        rd32(8'h38, 32'h8000_0000, "R2 src0");
        pulse_src(16);
        pulse_src(5);
        rd32(8'h38, 32'h8400_8000, "R2 src16 src5 sticky");
        rd32(8'h5C, 32'h0, "R3 no enable");
        chk_irq(1'b0, "R3 no enable");

        // R3 enable gating
        wr32(8'h34, 32'h0000_8000);
        rd32(8'h5C, 32'h0, "R3 mask without enable");
        wr32(8'h30, 32'h8000_0000);
        rd32(8'h5C, 32'h0000_0800, "R3 enable and mask");
        rd32(8'h50, 32'h0, "R4 conc mask zero");
        chk_irq(1'b0, "R4 conc mask zero");

        // R8 storage only
        wr32(8'h58, 32'hFFFF_FFFF);
        wr32(8'h08, 32'h1234_5678);
        wr32(8'h0C, 32'h9ABC_DEF0);
        rd32(8'h58, 32'hFFFF_FFFF, "R8 polarity");
        rd32(8'h08, 32'h1234_5678, "R8 route A");
        rd32(8'h0C, 32'h9ABC_DEF0, "R8 route B");
        chk_irq(1'b0, "R8 polarity no effect");

        // R4 / R5 latch into concentrator
        wr32(8'h54, 32'h0000_0800);
        chk_irq(1'b1, "R5 raised");
        rd32(8'h50, 32'h0000_0800, "R4 latched");

        // R7 clear while input live
        wr32(8'h50, 32'h0000_0800);
        rd32(8'h50, 32'h0000_0800, "R7 relatch");
        chk_irq(1'b1, "R7 relatch");

        // R6 host clear, partial
        wr32(8'h38, 32'h8000_0000);
        rd32(8'h38, 32'h0400_8000, "R6 host partial clear");
        rd32(8'h5C, 32'h0000_0800, "R3 still asserted");
        wr32(8'h38, 32'h0000_8000);
        rd32(8'h38, 32'h0400_0000, "R6 host clear");
        rd32(8'h5C, 32'h0, "R3 dropped");
        rd32(8'h50, 32'h0000_0800, "R4 sticky after drop");
        chk_irq(1'b1, "R4 sticky");
        wr32(8'h50, 32'h0000_0800);
        rd32(8'h50, 32'h0, "R6 conc clear");
        chk_irq(1'b0, "R5 lowered");

        // R3 enable toggling with a different source
        wr32(8'h30, 32'h0);
        wr32(8'h34, 32'h0400_0000);
        rd32(8'h5C, 32'h0, "R3 disabled");
        chk_irq(1'b0, "R3 disabled");
        wr32(8'h30, 32'h8000_0000);
        rd32(8'h5C, 32'h0000_0800, "R3 reenabled");
        chk_irq(1'b1, "R5 reenabled");

        // R9 unimplemented offsets
        rd32(8'h40, 32'hFFFF_FFFF, "R9 offset 40");
        rd32(8'hFC, 32'hFFFF_FFFF, "R9 offset FC");
        wr32(8'h35, 32'h0);
        wr32(8'h3C, 32'hFFFF_FFFF);
        rd32(8'h34, 32'h0400_0000, "R9 write ignored");
        rd32(8'h38, 32'h0400_0000, "R9 stat untouched");

        // R10 access size
        rd(8'h34, 3'd1, 32'hFFFF_FFFF, "R10 byte read");
        rd(8'h34, 3'd2, 32'hFFFF_FFFF, "R10 half read");
        access(1'b1, 8'h34, 3'd2, 32'h0);
        access(1'b1, 8'h38, 3'd1, 32'hFFFF_FFFF);
        rd32(8'h34, 32'h0400_0000, "R10 short write ignored");
        rd32(8'h38, 32'h0400_0000, "R10 short clear ignored");

        // R11 input register is read-only
        wr32(8'h5C, 32'h0);
        rd32(8'h5C, 32'h0000_0800, "R11 input read-only");

        // R12 no response to writes or idle
        wr32(8'h58, 32'h0);
        @(negedge clk);
        n_checks++;
        if (rsp_valid !== 1'b0) begin
            n_errors++;
            $display("FAIL R12 idle rsp_valid: actual %b expected 0", rsp_valid);
        end

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_checks++;
            n_errors++;
            $display("FAIL R12 missing responses: actual %0d pending expected 0", exp_q.size());
        end
        report();
    end

endmodule